// File: doc/BRIEF.md
# Rotating Floating-Point Register Stack

This block holds eight 64-bit registers that are addressed as a circular stack. A 3-bit top pointer selects the physical entry that currently acts as the stack head. Every physical entry has an occupancy tag. The block accepts one operation per cycle: push, pop, a relative read, a relative write, a read-modify-write, a fault-free examine, or a copy from the stack head into another slot. Each operation is checked against the tags. An operation that breaks the occupancy rules is refused, and the block raises a one-cycle fault strobe that says whether the fault came from an empty slot or an occupied one.

A surrounding execution unit issues the operations and supplies the values. Relative reads return data combinationally, so arithmetic can consume an operand in the same cycle. Popped data is registered. The block also keeps four condition bits. It packs them with the top pointer into a 16-bit status word. The top pointer, the tags and the condition bits can all be reloaded at once from a saved image when a context is restored.

Top module: `fp_regstack`

## Requirements
- R1: After a synchronous reset, the top pointer is 0, all eight tags are empty, the condition bits are 0, the status word is 0, and fault and pop_valid are low.
- R2: A push (op code 0) first moves top to (top-1) mod 8. It then writes the value into that physical entry and marks the entry occupied. If that entry was already occupied, the push is refused with a full fault.
- R3: A pop (op code 1) reads physical entry [top]. On the next cycle the value appears on pop_data with pop_valid high. The entry's tag is cleared and top becomes (top+1) mod 8. Popping an empty entry is refused with an empty fault.
- R4: Slot i refers to physical entry (top+i) mod 8. rdata and rtag show that entry's value and tag combinationally for the current slot input.
- R5: A relative read (op code 2) of an empty slot raises an empty fault.
- R6: A relative write (op code 3) stores the value and marks the slot occupied. A write to a slot that is already occupied is refused with a full fault.
- R7: A modify (op code 4) of an empty slot raises an empty fault. A modify of an occupied slot replaces its value and never raises a full fault.
- R8: An examine (op code 5) never raises a fault, whatever the tag of the slot.
- R9: A store (op code 6) copies the stack head into slot i and marks that slot occupied. It never raises a full fault, even when the slot is occupied. It raises an empty fault when the stack head is empty.
- R10: A refused operation leaves the registers, tags and top pointer unchanged. On the following cycle fault is high for exactly one cycle, and fault_kind is 0 for an empty fault or 1 for a full fault.
- R11: status_word carries top in bits 13:11, C3 in bit 14, and C2, C1, C0 in bits 10, 9, 8. All other bits are 0. A condition update keeps only the bits under mask 0x4700, so masking the status word with 0x4500 yields C3, C2 and C0.
- R12: A bulk load takes the low 3 bits of load_top and ignores the upper 29 bits. It also loads the eight tags (bit k is physical entry k) and the masked condition bits. A load takes priority over any operation in the same cycle, and that operation has no effect.
- R13: With op_valid low, or with op code 7, the cycle has no effect on the top pointer or the tags and raises no fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation request for this cycle |
| op_code | input | 3 | 0 push, 1 pop, 2 read, 3 write, 4 modify, 5 examine, 6 store, 7 none |
| slot | input | 3 | Relative slot index i |
| wdata | input | 64 | Value for push, write and modify |
| cond_we | input | 1 | Condition-bit update strobe |
| cond_in | input | 16 | New condition bits in status-word positions |
| load_en | input | 1 | Bulk load of pointer, tags and condition bits |
| load_top | input | 32 | Top pointer image; only bits 2:0 are used |
| load_tags | input | 8 | Tag image, bit k for physical entry k |
| load_cond | input | 16 | Condition-bit image in status-word positions |
| rdata | output | 64 | Value of slot i (combinational) |
| rtag | output | 1 | Tag of slot i (combinational) |
| pop_data | output | 64 | Registered popped value |
| pop_valid | output | 1 | pop_data was updated in the previous cycle |
| fault | output | 1 | One-cycle fault strobe |
| fault_kind | output | 1 | 0 empty fault, 1 full fault |
| status_word | output | 16 | Packed top pointer and condition bits |

## Verification
The bench pushes nine values in a row. This drives the pointer round the ring, and the ninth push must be refused as full. A design that failed to wrap or that skipped the tag check would overwrite the oldest entry. The two exemptions get their own cases: an examine of an empty slot, and a store onto an occupied slot. A design that used the general rules for these would fault where it must stay quiet. A bulk load comes with a pointer whose upper bits are all ones, in the same cycle as a push. Using more than three pointer bits, or letting the push go through, would show up as a wrong status word or a moved top. After every refused operation the bench reads back every slot. Any partial commit would appear as a changed tag, a changed value or a shifted top.

// File: rtl/fp_regstack.sv
module fp_regstack #(
  parameter int WIDTH   = 64,
  parameter int DEPTH   = 8,
  parameter int TOP_LSB = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [2:0]       slot,
  input  logic [WIDTH-1:0] wdata,
  input  logic             cond_we,
  input  logic [15:0]      cond_in,
  input  logic             load_en,
  input  logic [31:0]      load_top,
  input  logic [7:0]       load_tags,
  input  logic [15:0]      load_cond,
  output logic [WIDTH-1:0] rdata,
  output logic             rtag,
  output logic [WIDTH-1:0] pop_data,
  output logic             pop_valid,
  output logic             fault,
  output logic             fault_kind,
  output logic [15:0]      status_word
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW-1:0] ONE = PW'(1);
  localparam logic [15:0] COND_MASK = 16'h4700;
  localparam logic [2:0] OP_PUSH = 3'd0, OP_POP = 3'd1, OP_READ = 3'd2,
                         OP_WRITE = 3'd3, OP_MOD = 3'd4, OP_EXAM = 3'd5,
                         OP_STORE = 3'd6;

  logic [PW-1:0]    top_q;
  logic [DEPTH-1:0] tag_q;
  logic [WIDTH-1:0] ent_q [DEPTH];
  logic [15:0]      cond_q;

  logic [PW-1:0]    rel_idx, push_idx, new_top, wr_idx;
  logic [WIDTH-1:0] wr_val;
  logic             empty_f, full_f, wr_en, clr_en, acc, bad, commit;

  assign rel_idx  = top_q + slot[PW-1:0];
  assign push_idx = top_q - ONE;
  assign rdata    = ent_q[rel_idx];
  assign rtag     = tag_q[rel_idx];
  assign acc      = op_valid & ~load_en;

  always_comb begin
    empty_f = 1'b0;
    full_f  = 1'b0;
    wr_en   = 1'b0;
    clr_en  = 1'b0;
    wr_idx  = rel_idx;
    wr_val  = wdata;
    new_top = top_q;
    case (op_code)
      OP_PUSH: begin
        full_f  = tag_q[push_idx];
        wr_en   = 1'b1;
        wr_idx  = push_idx;
        new_top = push_idx;
      end
      OP_POP: begin
        empty_f = ~tag_q[top_q];
        clr_en  = 1'b1;
        new_top = top_q + ONE;
      end
      OP_READ:  empty_f = ~rtag;
      OP_WRITE: begin
        full_f = rtag;
        wr_en  = 1'b1;
      end
      OP_MOD: begin
        empty_f = ~rtag;
        wr_en   = 1'b1;
      end
      OP_STORE: begin
        empty_f = ~tag_q[top_q];
        wr_en   = 1'b1;
        wr_val  = ent_q[top_q];
      end
      default: ;
    endcase
  end

  assign bad    = acc & (empty_f | full_f);
  assign commit = acc & ~bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q      <= '0;
      tag_q      <= '0;
      cond_q     <= '0;
      fault      <= 1'b0;
      fault_kind <= 1'b0;
      pop_valid  <= 1'b0;
      pop_data   <= '0;
    end else begin
      fault      <= bad;
      fault_kind <= bad & full_f;
      pop_valid  <= commit && op_code == OP_POP;
      if (commit && op_code == OP_POP) pop_data <= ent_q[top_q];
      if (load_en) begin
        top_q  <= load_top[PW-1:0];
        tag_q  <= load_tags[DEPTH-1:0];
        cond_q <= load_cond & COND_MASK;
      end else begin
        if (cond_we) cond_q <= cond_in & COND_MASK;
        if (commit) begin
          top_q <= new_top;
          if (wr_en)  tag_q[wr_idx] <= 1'b1;
          if (clr_en) tag_q[top_q]  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit && wr_en) ent_q[wr_idx] <= wr_val;
  end

  assign status_word = cond_q | (16'(top_q) << TOP_LSB);

  assert_push_top_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && op_code == OP_PUSH) |=>
      (fault || status_word[TOP_LSB +: PW] == $past(top_q) - ONE));

  assert_pop_empty_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && op_code == OP_POP && !tag_q[top_q]) |=> (fault && !fault_kind));

  assert_exam_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (acc && op_code == OP_EXAM) |=> !fault);

  assert_store_no_full_R9: assert property (@(posedge clk) disable iff (rst)
    (acc && op_code == OP_STORE) |=> !(fault && fault_kind));

  assert_fault_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    (acc && (empty_f || full_f)) |=> ($stable(top_q) && $stable(tag_q) && fault));

  assert_load_top_R12: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (top_q == $past(load_top[PW-1:0]) && !fault));

  assert_idle_R13: assert property (@(posedge clk) disable iff (rst)
    (!load_en && (!op_valid || op_code == 3'd7)) |=>
      ($stable(top_q) && $stable(tag_q) && !fault));
endmodule

// File: tb/test_fp_regstack.sv
module test_fp_regstack;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, op_valid, cond_we, load_en;
  logic [2:0]  op_code, slot;
  logic [63:0] wdata;
  logic [15:0] cond_in, load_cond;
  logic [31:0] load_top;
  logic [7:0]  load_tags;
  logic [63:0] rdata, pop_data;
  logic        rtag, pop_valid, fault, fault_kind;
  logic [15:0] status_word;

  int checks = 0, errors = 0;
  int          m_top;
  bit          m_tag [8];
  bit          m_known [8];
  logic [63:0] m_val [8];

  fp_regstack i_fp_regstack (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .slot(slot),
    .wdata(wdata), .cond_we(cond_we), .cond_in(cond_in), .load_en(load_en),
    .load_top(load_top), .load_tags(load_tags), .load_cond(load_cond),
    .rdata(rdata), .rtag(rtag), .pop_data(pop_data), .pop_valid(pop_valid),
    .fault(fault), .fault_kind(fault_kind), .status_word(status_word));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(status_word[13:11] == 3'(m_top), req, 64'(status_word[13:11]), 64'(m_top));
    for (int i = 0; i < 8; i++) begin
      int idx = (m_top + i) % 8;
      slot = 3'(i);
      #1;
      chk(rtag === m_tag[idx], req, 64'(rtag), 64'(m_tag[idx]));
      if (m_tag[idx] && m_known[idx]) chk(rdata === m_val[idx], req, rdata, m_val[idx]);
    end
  endtask

  task automatic do_op(input logic [2:0] code, input int i, input logic [63:0] d,
                       input bit ef, input bit ek, input string req);
    int idx = (m_top + i) % 8;
    @(negedge clk);
    op_valid = 1'b1; op_code = code; slot = 3'(i); wdata = d;
    @(negedge clk);
    op_valid = 1'b0;
    chk(fault === ef, req, 64'(fault), 64'(ef));
    if (ef) chk(fault_kind === ek, req, 64'(fault_kind), 64'(ek));
    else begin
      case (code)
        3'd0: begin
          m_top = (m_top + 7) % 8;
          m_val[m_top] = d; m_tag[m_top] = 1; m_known[m_top] = 1;
        end
        3'd1: begin
          chk(pop_valid === 1'b1, req, 64'(pop_valid), 64'd1);
          if (m_known[m_top]) chk(pop_data === m_val[m_top], req, pop_data, m_val[m_top]);
          m_tag[m_top] = 0;
          m_top = (m_top + 1) % 8;
        end
        3'd3, 3'd4: begin
          m_val[idx] = d; m_tag[idx] = 1; m_known[idx] = 1;
        end
        3'd6: begin
          m_val[idx] = m_val[m_top]; m_known[idx] = m_known[m_top]; m_tag[idx] = 1;
        end
        default: ;
      endcase
    end
    @(negedge clk);
    chk(fault === 1'b0, "R10 strobe length", 64'(fault), 64'd0);
    check_state(req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b0; cond_we = 1'b0; load_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_top = 0;
    for (int i = 0; i < 8; i++) m_tag[i] = 0;
    chk(status_word === 16'h0, "R1 status", 64'(status_word), 64'd0);
    chk(fault === 1'b0 && pop_valid === 1'b0, "R1 strobes", 64'({fault, pop_valid}), 64'd0);
    check_state("R1 tags");
  endtask

  task automatic t_push_pop();
    t_reset();
    do_op(3'd0, 0, 64'hAAAA_0000_0000_0001, 0, 0, "R2 push");
    do_op(3'd0, 0, 64'hBBBB_0000_0000_0002, 0, 0, "R2 push");
    do_op(3'd0, 0, 64'hCCCC_0000_0000_0003, 0, 0, "R4 relative view");
    chk(status_word[13:11] == 3'd5, "R2 top", 64'(status_word[13:11]), 64'd5);
    do_op(3'd1, 0, 64'h0, 0, 0, "R3 pop");
    do_op(3'd1, 0, 64'h0, 0, 0, "R3 pop");
  endtask

  task automatic t_wrap();
    t_reset();
    for (int k = 0; k < 8; k++) do_op(3'd0, 0, 64'h1000 + 64'(k), 0, 0, "R2 fill");
    do_op(3'd0, 0, 64'hDEAD, 1, 1, "R2 R10 full push");
    for (int k = 0; k < 8; k++) do_op(3'd1, 0, 64'h0, 0, 0, "R3 drain");
    do_op(3'd1, 0, 64'h0, 1, 0, "R3 R10 empty pop");
  endtask

  task automatic t_empty_faults();
    t_reset();
    do_op(3'd2, 3, 64'h0, 1, 0, "R5 read empty");
    do_op(3'd4, 1, 64'h55, 1, 0, "R7 modify empty");
    do_op(3'd6, 2, 64'h0, 1, 0, "R9 store from empty head");
  endtask

  task automatic t_write_modify();
    t_reset();
    do_op(3'd3, 2, 64'h1234_5678_9ABC_DEF0, 0, 0, "R6 write empty");
    do_op(3'd3, 2, 64'h1111, 1, 1, "R6 R10 write occupied");
    do_op(3'd4, 2, 64'h0F0F_0F0F_0F0F_0F0F, 0, 0, "R7 modify occupied");
    do_op(3'd2, 2, 64'h0, 0, 0, "R5 read occupied");
  endtask

  task automatic t_examine();
    t_reset();
    do_op(3'd5, 5, 64'h0, 0, 0, "R8 examine empty");
    do_op(3'd0, 0, 64'h77, 0, 0, "R2 push");
    do_op(3'd5, 0, 64'h0, 0, 0, "R8 examine occupied");
  endtask

  task automatic t_store();
    t_reset();
    do_op(3'd0, 0, 64'hFEED_0000_0000_00AA, 0, 0, "R2 push");
    do_op(3'd3, 3, 64'h9999, 0, 0, "R6 write");
    do_op(3'd6, 3, 64'h0, 0, 0, "R9 store onto occupied");
    do_op(3'd6, 4, 64'h0, 0, 0, "R9 store onto empty");
  endtask

  task automatic t_status();
    t_reset();
    do_op(3'd0, 0, 64'h1, 0, 0, "R2 push");
    @(negedge clk); cond_we = 1'b1; cond_in = 16'hFFFF;
    @(negedge clk); cond_we = 1'b0;
    chk(status_word === 16'h7F00, "R11 all cond bits", 64'(status_word), 64'h7F00);
    chk((status_word & 16'h4500) === 16'h4500, "R11 C3 C2 C0 mask", 64'(status_word & 16'h4500), 64'h4500);
    @(negedge clk); cond_we = 1'b1; cond_in = 16'h0100;
    @(negedge clk); cond_we = 1'b0;
    chk(status_word === 16'h3900, "R11 C0 only", 64'(status_word), 64'h3900);
  endtask

  task automatic t_load();
    t_reset();
    @(negedge clk);
    load_en = 1'b1; load_top = 32'hFFFF_FFFA; load_tags = 8'hA5; load_cond = 16'hFFFF;
    op_valid = 1'b1; op_code = 3'd0; wdata = 64'hBAD;
    @(negedge clk);
    load_en = 1'b0; op_valid = 1'b0;
    m_top = 2;
    for (int k = 0; k < 8; k++) m_tag[k] = bit'((8'hA5 >> k) & 8'h1);
    chk(status_word === 16'h5700, "R12 R11 loaded status", 64'(status_word), 64'h5700);
    chk(fault === 1'b0, "R12 no fault", 64'(fault), 64'd0);
    check_state("R12 loaded tags");
    do_op(3'd2, 1, 64'h0, 1, 0, "R12 loaded empty slot");
    do_op(3'd3, 0, 64'h0, 1, 1, "R12 loaded full slot");
  endtask

  task automatic t_idle();
    t_reset();
    do_op(3'd0, 0, 64'h42, 0, 0, "R2 push");
    @(negedge clk); op_valid = 1'b0; op_code = 3'd0; wdata = 64'h99;
    @(negedge clk);
    chk(fault === 1'b0, "R13 idle", 64'(fault), 64'd0);
    check_state("R13 idle state");
    do_op(3'd7, 3, 64'h88, 0, 0, "R13 reserved code");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_code = 3'd7; slot = 3'd0; wdata = '0;
    cond_we = 1'b0; cond_in = '0; load_en = 1'b0; load_top = '0; load_tags = '0; load_cond = '0;
    for (int k = 0; k < 8; k++) begin m_known[k] = 0; m_val[k] = '0; m_tag[k] = 0; end
    t_push_pop();
    t_wrap();
    t_empty_faults();
    t_write_modify();
    t_examine();
    t_store();
    t_status();
    t_load();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule